// File: doc/BRIEF.md
# Row Open Time Limiter

This block guards one DRAM bank inside a memory controller. It measures how long the row opened by the last activate has stayed open. It tells the command scheduler when a precharge may legally be issued. It also raises a mandatory close request once the row has been open for the longest time the refresh scheme tolerates. A scheduler that keeps finding row hits could otherwise hold a row open indefinitely. That would starve the bank of refresh, because a refresh is itself an activate followed by a precharge.

The scheduler sends single-cycle activate and precharge strobes for the bank. It also reports whether a pending request hits the open row. A temperature-range flag selects between the normal refresh interval and the shortened one used when the device runs hot. All timing limits are parameters expressed in controller clock cycles. The ceiling equals a multiple of the refresh interval, and that interval is halved in the hot range. The block grants row hits only while no forced close is pending.

Top module: `row_open_guard`

## Requirements
- R1: While rst_ni is low and until the first activate after reset, row_open_o, pre_ok_o, force_close_o, hit_grant_o and pre_err_o are all 0, whatever row_hit_i shows.
- R2: An activate strobe sampled while the bank is idle sets row_open_o on the next cycle and starts the open-time count at 1. An activate sampled while a row is already open is ignored and does not restart the count.
- R3: pre_ok_o is 1 exactly when a row is open and at least RAS_MIN_CYC clock edges have passed since the accepted activate. With the count defined as in R2, this means count >= RAS_MIN_CYC.
- R4: In the normal temperature range (hot_i = 0), force_close_o rises in the cycle where the count reaches REFI_MULT * REFI_CYC.
- R5: In the hot range (hot_i = 1), the ceiling is REFI_MULT * (REFI_CYC >> HOT_SHIFT). With the default HOT_SHIFT of 1 this is half the normal ceiling.
- R6: Row hits never extend the open time. hit_grant_o equals row_open_o AND row_hit_i AND NOT force_close_o, so force_close_o asserts while hits are still pending.
- R7: Once asserted, force_close_o stays 1 until a precharge is accepted. This holds even if hot_i later drops and raises the ceiling, and even after the count saturates.
- R8: A precharge accepted while a row is open clears row_open_o, pre_ok_o and force_close_o on the next cycle and clears the count. The next activate restarts the count from 1.
- R9: A precharge sampled while a row is open and the count is below RAS_MIN_CYC makes pre_err_o 1 for exactly the next cycle. A precharge to an idle bank has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Activate strobe for this bank |
| pre_i | input | 1 | Precharge strobe for this bank |
| row_hit_i | input | 1 | A pending request targets the open row |
| hot_i | input | 1 | High temperature range selected |
| row_open_o | output | 1 | A row is active in the bank |
| pre_ok_o | output | 1 | Minimum active time met, precharge allowed |
| force_close_o | output | 1 | Ceiling reached, precharge mandatory |
| hit_grant_o | output | 1 | Row hit may be served |
| pre_err_o | output | 1 | Precharge arrived before the minimum time |

## Verification
The bench builds the block with RAS_MIN_CYC = 5, REFI_CYC = 8, REFI_MULT = 9 and HOT_SHIFT = 1. These values give ceilings of 72 cycles in the normal range and 36 in the hot range, and a 7-bit count that saturates at 127. A few hundred cycles are therefore enough to reach the ceiling in both temperature ranges. They also let the bench hold a forced close past counter saturation and across a drop of the temperature flag, and retry an activate several times. The minimum of 5 cycles leaves room to precharge early, to activate again inside the window, and to observe pre_ok_o rising on its exact edge.

// File: rtl/row_guard_pkg.sv
package row_guard_pkg;

  typedef enum logic {
    BANK_IDLE = 1'b0,
    BANK_OPEN = 1'b1
  } bank_state_e;

  function automatic int unsigned row_ceiling(input int unsigned refi,
                                              input int unsigned mult,
                                              input int unsigned shift);
    return mult * (refi >> shift);
  endfunction

endpackage

// File: rtl/rog_bank_fsm.sv
module rog_bank_fsm
  import row_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  logic        pre_i,
  output bank_state_e state_o,
  output logic        open_start_o,
  output logic        close_o
);

  bank_state_e state_q, state_d;

  // activate while open and precharge while idle are dropped
  assign open_start_o = (state_q == BANK_IDLE) && act_i;
  assign close_o      = (state_q == BANK_OPEN) && pre_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BANK_IDLE: if (act_i) state_d = BANK_OPEN;
      BANK_OPEN: if (pre_i) state_d = BANK_IDLE;
      default:   state_d = BANK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BANK_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/rog_open_timer.sv
module rog_open_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_i)                    cnt_q <= '0;
    else if (start_i)                    cnt_q <= CNT_W'(1);
    else if (run_i && cnt_q != CNT_SAT)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rog_limit_sel.sv
module rog_limit_sel #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned RAS_MIN_CYC = 27,
  parameter int unsigned REFI_CYC    = 6240,
  parameter int unsigned REFI_MULT   = 9,
  parameter int unsigned HOT_SHIFT   = 1
) (
  input  logic             open_i,
  input  logic             hot_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             min_met_o,
  output logic             ceil_hit_o
);
  import row_guard_pkg::*;

  localparam logic [CNT_W-1:0] MIN_V    = CNT_W'(RAS_MIN_CYC);
  localparam logic [CNT_W-1:0] CEIL_N_V = CNT_W'(row_ceiling(REFI_CYC, REFI_MULT, 0));
  localparam logic [CNT_W-1:0] CEIL_H_V = CNT_W'(row_ceiling(REFI_CYC, REFI_MULT, HOT_SHIFT));

  logic [CNT_W-1:0] ceil_sel;

  generate
    if (HOT_SHIFT == 0) begin : g_flat
      logic unused_hot;
      assign unused_hot = hot_i;
      assign ceil_sel   = CEIL_N_V;
    end else begin : g_derate
      assign ceil_sel = hot_i ? CEIL_H_V : CEIL_N_V;
    end
  endgenerate

  assign min_met_o  = open_i && (cnt_i >= MIN_V);
  assign ceil_hit_o = open_i && (cnt_i >= ceil_sel);

endmodule

// File: rtl/row_open_guard.sv
module row_open_guard #(
  parameter int unsigned RAS_MIN_CYC = 27,
  parameter int unsigned REFI_CYC    = 6240,
  parameter int unsigned REFI_MULT   = 9,
  parameter int unsigned HOT_SHIFT   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  input  logic row_hit_i,
  input  logic hot_i,
  output logic row_open_o,
  output logic pre_ok_o,
  output logic force_close_o,
  output logic hit_grant_o,
  output logic pre_err_o
);
  import row_guard_pkg::*;

  localparam int unsigned CEIL_MAX = REFI_MULT * REFI_CYC;
  localparam int unsigned CNT_W    = $clog2(CEIL_MAX + 1);

  bank_state_e      state;
  logic             open_start, close;
  logic             is_open;
  logic [CNT_W-1:0] cnt;
  logic             min_met, ceil_hit;
  logic             force_q, err_q;

  rog_bank_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act_i),
    .pre_i        (pre_i),
    .state_o      (state),
    .open_start_o (open_start),
    .close_o      (close)
  );

  assign is_open = (state == BANK_OPEN);

  rog_open_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (open_start),
    .clear_i (close),
    .run_i   (is_open),
    .cnt_o   (cnt)
  );

  rog_limit_sel #(
    .CNT_W       (CNT_W),
    .RAS_MIN_CYC (RAS_MIN_CYC),
    .REFI_CYC    (REFI_CYC),
    .REFI_MULT   (REFI_MULT),
    .HOT_SHIFT   (HOT_SHIFT)
  ) u_limit (
    .open_i     (is_open),
    .hot_i      (hot_i),
    .cnt_i      (cnt),
    .min_met_o  (min_met),
    .ceil_hit_o (ceil_hit)
  );

  // sticky: a later rise of the ceiling must not withdraw the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          force_q <= 1'b0;
    else if (!is_open)    force_q <= 1'b0;
    else if (close)       force_q <= 1'b0;
    else                  force_q <= force_q | ceil_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= close && !min_met;
  end

  assign row_open_o    = is_open;
  assign pre_ok_o      = min_met;
  assign force_close_o = is_open && (force_q || ceil_hit);
  assign hit_grant_o   = is_open && row_hit_i && !force_close_o;
  assign pre_err_o     = err_q;

endmodule

// File: rtl/row_open_guard_chk.sv
module row_open_guard_chk #(
  parameter int unsigned RAS_MIN_CYC = 27,
  parameter int unsigned REFI_CYC    = 6240,
  parameter int unsigned REFI_MULT   = 9,
  parameter int unsigned HOT_SHIFT   = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic act_i,
  input logic pre_i,
  input logic row_hit_i,
  input logic hot_i,
  input logic row_open_o,
  input logic pre_ok_o,
  input logic force_close_o,
  input logic hit_grant_o,
  input logic pre_err_o
);

  localparam int unsigned CEIL_H = REFI_MULT * (REFI_CYC >> HOT_SHIFT);

  int unsigned open_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   open_cyc <= 0;
    else if (!row_open_o && act_i) open_cyc <= 1;
    else if (row_open_o && pre_i)  open_cyc <= 0;
    else if (row_open_o && open_cyc != 32'hFFFF_FFFF) open_cyc <= open_cyc + 1;
  end

  // R2
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_open_o && act_i) |=> row_open_o);

  // R3
  min_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_ok_o |-> (row_open_o && open_cyc >= RAS_MIN_CYC));

  // R5
  no_early_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_close_o |-> (row_open_o && open_cyc >= CEIL_H));

  // R6
  hit_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_grant_o |-> (row_hit_i && !force_close_o));

  // R7
  force_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_close_o && !pre_i) |=> force_close_o);

  // R8
  pre_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_open_o && pre_i) |=> (!row_open_o && !pre_ok_o && !force_close_o));

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_err_o |-> $past(pre_i && row_open_o));

endmodule

bind row_open_guard row_open_guard_chk #(
  .RAS_MIN_CYC (RAS_MIN_CYC),
  .REFI_CYC    (REFI_CYC),
  .REFI_MULT   (REFI_MULT),
  .HOT_SHIFT   (HOT_SHIFT)
) u_chk (.*);

// File: tb/row_open_guard_test.sv
module row_open_guard_test;

  localparam int MIN    = 5;
  localparam int REFI   = 8;
  localparam int MULT   = 9;
  localparam int SHIFT  = 1;
  localparam int CEIL_N = MULT * REFI;
  localparam int CEIL_H = MULT * (REFI >> SHIFT);
  localparam int CNT_MAX = (1 << $clog2(CEIL_N + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic act = 1'b0, pre = 1'b0, hit = 1'b0, hot = 1'b0;
  logic row_open, pre_ok, force_close, hit_grant, pre_err;

  always #10 clk = ~clk;

  row_open_guard #(
    .RAS_MIN_CYC (MIN),
    .REFI_CYC    (REFI),
    .REFI_MULT   (MULT),
    .HOT_SHIFT   (SHIFT)
  ) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .act_i         (act),
    .pre_i         (pre),
    .row_hit_i     (hit),
    .hot_i         (hot),
    .row_open_o    (row_open),
    .pre_ok_o      (pre_ok),
    .force_close_o (force_close),
    .hit_grant_o   (hit_grant),
    .pre_err_o     (pre_err)
  );

  typedef struct {
    logic  o, ok, fc, gr, er;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // requirement-level model state
  bit m_open = 0, m_fs = 0, m_err = 0;
  int m_cnt = 0;

  task automatic cmp(input logic act_v, input logic exp_v, input string nm, input string tag);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, nm, act_v, exp_v, $time);
    end
  endtask

  task automatic drive(input logic r, input logic a, input logic p,
                       input logic h, input logic t, input string tag);
    exp_t e;
    int   ceil;
    bit   fc_old;
    @(negedge clk);
    rst_n = r; act = a; pre = p; hit = h; hot = t;
    ceil = t ? CEIL_H : CEIL_N;
    if (!r) begin
      m_open = 0; m_cnt = 0; m_fs = 0; m_err = 0;
    end else begin
      m_err  = p && m_open && (m_cnt < MIN);
      fc_old = m_fs || (m_open && m_cnt >= ceil);
      if (m_open && p) begin
        m_open = 0; m_cnt = 0; m_fs = 0;
      end else if (!m_open && a) begin
        m_open = 1; m_cnt = 1; m_fs = 0;
      end else if (m_open) begin
        if (m_cnt < CNT_MAX) m_cnt++;
        m_fs = fc_old;
      end
    end
    e.o   = m_open;
    e.ok  = m_open && (m_cnt >= MIN);
    e.fc  = m_fs || (m_open && m_cnt >= ceil);
    e.gr  = m_open && h && !e.fc;
    e.er  = m_err;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares after each active edge, clear of input changes
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(row_open,    e.o,  "row_open",    e.tag);
      cmp(pre_ok,      e.ok, "pre_ok",      e.tag);
      cmp(force_close, e.fc, "force_close", e.tag);
      cmp(hit_grant,   e.gr, "hit_grant",   e.tag);
      cmp(pre_err,     e.er, "pre_err",     e.tag);
    end
  end

  initial begin
    #3 rst_n = 1'b0;
    #1;
    // R1 asynchronous reset before any edge
    cmp(row_open, 1'b0, "row_open", "R1");
    cmp(force_close, 1'b0, "force_close", "R1");
    repeat (3) drive(0, 0, 0, 1, 0, "R1");
    repeat (2) drive(1, 0, 0, 1, 0, "R1");
    // R2 open, R3 minimum gate
    drive(1, 1, 0, 0, 0, "R2");
    repeat (3) drive(1, 0, 0, 0, 0, "R3");
    drive(1, 1, 0, 0, 0, "R2");
    repeat (3) drive(1, 0, 0, 0, 0, "R3");
    // R6 continuous hits, R4 normal ceiling
    for (int i = 0; i < 72; i++) drive(1, 0, 0, 1, 0, (i < 55) ? "R6" : "R4");
    // R7 held past saturation
    for (int i = 0; i < 60; i++) drive(1, 0, 0, 1, 0, "R7");
    // R8 close leaves bank idle
    drive(1, 0, 1, 1, 0, "R8");
    repeat (2) drive(1, 0, 0, 1, 0, "R8");
    // R9 idle precharge, then early precharge
    drive(1, 0, 1, 0, 0, "R9");
    drive(1, 1, 0, 0, 0, "R9");
    repeat (2) drive(1, 0, 0, 0, 0, "R9");
    drive(1, 0, 1, 0, 0, "R9");
    repeat (2) drive(1, 0, 0, 0, 0, "R9");
    // R8 timer restarts from one
    drive(1, 1, 0, 0, 0, "R8");
    repeat (6) drive(1, 0, 0, 0, 0, "R8");
    drive(1, 0, 1, 0, 0, "R8");
    // R5 hot ceiling, R7 survives hot dropping
    drive(1, 1, 0, 1, 1, "R5");
    for (int i = 0; i < 40; i++) drive(1, 0, 0, 1, 1, "R5");
    for (int i = 0; i < 10; i++) drive(1, 0, 0, 1, 0, "R7");
    drive(1, 0, 1, 1, 0, "R8");
    repeat (3) drive(1, 0, 0, 0, 0, "R8");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule